// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs clause-22 management transactions towards an external PHY over a two-wire serial management link. A single 32-bit command word describes the whole transaction, and writing it launches the frame. The word holds a two-bit start code, a two-bit opcode, a five-bit PHY address, a five-bit register address, a two-bit turnaround and sixteen data bits. The block first sends a full preamble of 32 ones and then shifts the command word out most-significant bit first. On a read it lets go of the data line at the turnaround and collects the sixteen bits that the PHY returns.

The management clock comes from the system clock through a programmable half-period counter. When the frame ends, a sticky flag is raised in an event word and software clears it by writing a one to it. For a read, the returned sixteen bits replace the low half of the command word. A `busy` output covers the whole frame, and command writes that arrive while it is high have no effect.

Top module: `mdio_master`

## Requirements
- R1: A command write when `busy` is low and the speed register is nonzero loads `mgmt_data` with the written word, and `busy` reads high from the next clock.
- R2: A frame is 64 bit times: 32 ones, then `mgmt_data` bits 31 down to 0. Each bit is presented while MDC is low and changes only when MDC falls.
- R3: Bits [29:28] equal to 2'b10 mark a read. When a read completes, `mgmt_data[15:0]` holds the 16 bits sampled on MDC rising edges in bit times 48 to 63, first sample in bit 15, and bits [31:16] keep the command.
- R4: A read releases the line (`mdio_oe` low) from bit time 46 to the end of the frame. A write drives the line for all 64 bit times. The line is released when idle.
- R5: MDC is low for S system clocks and then high for S clocks in every bit time, where S is the speed value latched at launch, so f_MDC = f_clk/(2·S). Speed writes during a frame do not affect it. MDC is low when idle.
- R6: A command write while `busy` is high has no effect on `mgmt_data` or on the frame in progress.
- R7: `busy` stays high for exactly 128·S clocks. On the clock it falls, `evt_flags[23]` is set and stays set.
- R8: An event write with bit 23 set clears `evt_flags[23]`. An event write with bit 23 clear leaves it unchanged. All other event bits read zero.
- R9: When a frame completes in the same cycle as an event write that clears bit 23, the flag ends up set.
- R10: While the speed register is zero, command writes are ignored: `busy`, MDC and `mgmt_data` do not change.
- R11: A write frame leaves `mgmt_data` holding the command word after completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word to write |
| spd_wr | input | 1 | Speed register write strobe |
| spd_wdata | input | SPD_W | MDC half-period in system clocks |
| evt_wr | input | 1 | Event register write strobe (write-one-to-clear) |
| evt_wdata | input | 32 | Event clear mask, bit 23 used |
| mgmt_data | output | 32 | Command/data register contents |
| evt_flags | output | 32 | Event register, completion flag at bit 23 |
| busy | output | 1 | High from launch until completion |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Management data from the line |
| mdio_o | output | 1 | Management data to the line |
| mdio_oe | output | 1 | Drive enable for the data line |

## Verification
Two pairs of functions can land on the same cycle: setting the completion flag and a software clear of that flag, and the end of a frame and a new command write. The bench's reference model tracks elapsed clocks since launch. It uses that count to place an event clear exactly on the completion cycle, and it expects the flag to read set afterwards. Command and speed writes are also issued in the middle of a read frame. They are judged by the frame length and by the final data word, which must show the original command in its upper half and the PHY's reply in its lower half.

// File: rtl/mdio_pkg.sv
// Package: shared constants of the management frame master.
// Assumes a 64-bit-time frame: 32 preamble ones followed by a 32-bit command word.
package mdio_pkg;
    localparam int          BIT_W     = 6;
    localparam int          PRE_LEN   = 32;
    localparam int          EVT_BIT   = 23;
    localparam int          OP_HI     = 29;
    localparam int          OP_LO     = 28;
    localparam logic [1:0]  OP_READ   = 2'b10;
    localparam logic [BIT_W-1:0] B_DATA0 = 6'd32;  // first command bit time
    localparam logic [BIT_W-1:0] B_REL   = 6'd46;  // read releases line here
    localparam logic [BIT_W-1:0] B_CAP   = 6'd48;  // first sampled read bit
    localparam logic [BIT_W-1:0] B_LAST  = 6'd63;  // final bit time
endpackage

// File: rtl/mdio_clkgen.sv
// Module: MDC generator. Produces MDC low for HALF clocks then high for HALF
// clocks while run is high, plus one-cycle ticks marking the clock in which
// MDC is about to rise or fall. Assumes half is nonzero whenever run is high.
module mdio_clkgen #(
    parameter int SPD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SPD_W-1:0] half,
    output logic             mdc,
    output logic             tick_rise,
    output logic             tick_fall
);
    logic [SPD_W-1:0] cnt_q;
    logic             mdc_q;
    logic             at_end;

    assign at_end    = (cnt_q == half - SPD_W'(1));
    assign tick_rise = run && at_end && !mdc_q;
    assign tick_fall = run && at_end && mdc_q;
    assign mdc       = mdc_q;

    // Half-period counter and MDC toggle; parked low while not running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (at_end) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + SPD_W'(1);
        end
    end

    AST_MDC_RISE_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc_q) |-> $past(run)); // R5
endmodule

// File: rtl/mdio_seq.sv
// Module: frame sequencer. Tracks the bit time, presents preamble and command
// bits on the line, releases the line for read turnaround and data, and
// shifts in read data on MDC rising ticks. Assumes cmd is stable while run.
module mdio_seq
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run,
    input  logic [31:0] cmd,
    input  logic        tick_rise,
    input  logic        tick_fall,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] rd_word,
    output logic        frame_done
);
    logic [BIT_W-1:0] bit_q;
    logic [15:0]      sh_q;
    logic [63:0]      frame;
    logic             is_read;

    assign is_read    = (cmd[OP_HI:OP_LO] == OP_READ);
    assign frame      = {{PRE_LEN{1'b1}}, cmd};
    assign frame_done = tick_fall && (bit_q == B_LAST);
    assign mdio_oe    = run && (!is_read || (bit_q < B_REL));
    // ~bit_q selects frame bit 63 - bit_q, i.e. most significant first.
    assign mdio_o     = mdio_oe && frame[~bit_q];
    assign rd_word    = sh_q;

    // Bit-time counter, advanced at each MDC fall; read data shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= '0;
            sh_q  <= '0;
        end else begin
            if (!run)
                bit_q <= '0;
            else if (tick_fall)
                bit_q <= (bit_q == B_LAST) ? '0 : bit_q + 6'd1;
            if (tick_rise && is_read && (bit_q >= B_CAP))
                sh_q <= {sh_q[14:0], mdio_i};
        end
    end

    AST_PREAMBLE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (run && bit_q < B_DATA0) |-> (mdio_o && mdio_oe)); // R2
    AST_BIT_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick_fall) |=> $stable(bit_q)); // R2
    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && is_read && bit_q >= B_REL) |-> !mdio_oe); // R4
    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !is_read) |-> mdio_oe); // R4
endmodule

// File: rtl/mdio_master.sv
// Module: management frame master top. Holds the command/data word, the
// latched speed, the sticky completion flag and busy; launches a frame on a
// command write when idle and the speed is nonzero. Assumes one PHY-side
// device on the line and software that writes the turnaround bits itself.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int SPD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [31:0]      cmd_wdata,
    input  logic             spd_wr,
    input  logic [SPD_W-1:0] spd_wdata,
    input  logic             evt_wr,
    input  logic [31:0]      evt_wdata,
    output logic [31:0]      mgmt_data,
    output logic [31:0]      evt_flags,
    output logic             busy,
    output logic             mdc,
    input  logic             mdio_i,
    output logic             mdio_o,
    output logic             mdio_oe
);
    logic [SPD_W-1:0] spd_q;
    logic [SPD_W-1:0] half_q;
    logic [31:0]      data_q;
    logic             busy_q;
    logic             evt_q;
    logic             launch;
    logic             is_read;
    logic             tick_rise;
    logic             tick_fall;
    logic             frame_done;
    logic [15:0]      rd_word;
    logic             unused_evt_bits;

    assign launch          = cmd_wr && !busy_q && (spd_q != '0);
    assign is_read         = (data_q[OP_HI:OP_LO] == OP_READ);
    assign unused_evt_bits = ^{evt_wdata[31:EVT_BIT+1], evt_wdata[EVT_BIT-1:0]};
    assign mgmt_data       = data_q;
    assign busy            = busy_q;

    // Speed register, written freely; sampled only at launch.
    always_ff @(posedge clk) begin
        if (!rst_n)      spd_q <= '0;
        else if (spd_wr) spd_q <= spd_wdata;
    end

    // Launch/complete control: command word, latched half-period, busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            half_q <= '0;
            busy_q <= 1'b0;
        end else if (launch) begin
            data_q <= cmd_wdata;
            half_q <= spd_q;
            busy_q <= 1'b1;
        end else if (frame_done) begin
            busy_q <= 1'b0;
            if (is_read) data_q[15:0] <= rd_word;
        end
    end

    // Sticky completion flag; a completion beats a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                        evt_q <= 1'b0;
        else if (frame_done)               evt_q <= 1'b1;
        else if (evt_wr && evt_wdata[EVT_BIT]) evt_q <= 1'b0;
    end

    // Event word view: only the completion bit is populated.
    always_comb begin
        evt_flags          = '0;
        evt_flags[EVT_BIT] = evt_q;
    end

    mdio_clkgen #(.SPD_W(SPD_W)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy_q),
        .half      (half_q),
        .mdc       (mdc),
        .tick_rise (tick_rise),
        .tick_fall (tick_fall)
    );

    mdio_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (busy_q),
        .cmd        (data_q),
        .tick_rise  (tick_rise),
        .tick_fall  (tick_fall),
        .mdio_i     (mdio_i),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .rd_word    (rd_word),
        .frame_done (frame_done)
    );

    AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !mdc); // R5
    AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cmd_wr && !frame_done) |=> $stable(data_q)); // R6
    AST_DONE_SETS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> evt_flags[EVT_BIT]); // R7
    AST_BUSY_FALL_WITH_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> evt_q); // R7
    AST_ZERO_SPEED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (spd_q == '0 && !busy_q) |=> !busy_q); // R10
endmodule

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic        spd_wr = 1'b0;
    logic [7:0]  spd_wdata = '0;
    logic        evt_wr = 1'b0;
    logic [31:0] evt_wdata = '0;
    logic [31:0] mgmt_data, evt_flags;
    logic        busy, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    // reference model state
    logic        m_busy = 1'b0;
    int          m_k = 0;
    int          m_h = 0;
    logic [31:0] m_data = '0;
    logic        m_evt = 1'b0;
    logic [7:0]  m_spd = '0;
    logic [15:0] phy_resp = 16'h0000;
    logic        done_m;

    always #4 clk = ~clk;

    mdio_master u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .spd_wr(spd_wr), .spd_wdata(spd_wdata), .evt_wr(evt_wr),
        .evt_wdata(evt_wdata), .mgmt_data(mgmt_data), .evt_flags(evt_flags),
        .busy(busy), .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, got, exp, cyc);
        end
    endtask

    // Behavioural model: elapsed clocks since launch drive everything.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_busy <= 1'b0; m_k <= 0; m_h <= 0; m_data <= '0;
            m_evt <= 1'b0; m_spd <= '0;
        end else begin
            done_m = m_busy && (m_k == 128 * m_h - 1);
            if (m_busy) begin
                if (done_m) begin
                    m_busy <= 1'b0;
                    if (m_data[29:28] == 2'b10) m_data[15:0] <= phy_resp;
                end else m_k <= m_k + 1;
            end else if (cmd_wr && m_spd != 0) begin
                m_busy <= 1'b1; m_k <= 0; m_h <= int'(m_spd); m_data <= cmd_wdata;
            end
            if (done_m) m_evt <= 1'b1;
            else if (evt_wr && evt_wdata[23]) m_evt <= 1'b0;
            if (spd_wr) m_spd <= spd_wdata;
        end
    end

    // Per-cycle comparison and PHY-side reply, both away from the rising edge.
    always @(negedge clk) begin
        if (rst_n) begin
            int  bt;
            logic rd, e_mdc, e_oe, e_o;
            bt    = m_busy ? m_k / (2 * m_h) : 0;
            rd    = (m_data[29:28] == 2'b10);
            e_mdc = m_busy ? logic'((m_k / m_h) % 2) : 1'b0;
            e_oe  = m_busy && (!rd || bt < 46);
            e_o   = (bt < 32) ? 1'b1 : m_data[63 - bt];
            chk("R5", "mdc", 32'(mdc), 32'(e_mdc));
            chk("R7", "busy", 32'(busy), 32'(m_busy));
            chk("R4", "mdio_oe", 32'(mdio_oe), 32'(e_oe));
            if (e_oe) chk("R2", "mdio_o", 32'(mdio_o), 32'(e_o));
            chk("R8", "evt_flags", evt_flags, 32'(m_evt) << 23);
            chk("R3", "mgmt_data", mgmt_data, m_data);
            if (m_busy && rd && bt >= 48) mdio_i = phy_resp[63 - bt];
            else mdio_i = 1'b1;
        end
    end

    task automatic wr_cmd(input logic [31:0] d);
        @(negedge clk); cmd_wr = 1'b1; cmd_wdata = d;
        @(negedge clk); cmd_wr = 1'b0;
    endtask
    task automatic wr_spd(input logic [7:0] v);
        @(negedge clk); spd_wr = 1'b1; spd_wdata = v;
        @(negedge clk); spd_wr = 1'b0;
    endtask
    task automatic wr_evt(input logic [31:0] d);
        @(negedge clk); evt_wr = 1'b1; evt_wdata = d;
        @(negedge clk); evt_wr = 1'b0;
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R7 watchdog: actual busy %0b expected completion", busy);
        summary();
    end

    initial begin
        int t0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7", "reset busy", 32'(busy), 0);
        chk("R8", "reset events", evt_flags, 0);
        chk("R5", "reset mdc", 32'(mdc), 0);

        // R10: zero speed blocks launch
        wr_cmd(32'h51C6BEEF);
        repeat (3) @(negedge clk);
        chk("R10", "busy at zero speed", 32'(busy), 0);
        chk("R10", "data at zero speed", mgmt_data, 0);
        chk("R10", "mdc at zero speed", 32'(mdc), 0);

        // R1/R2/R7/R11: write frame at S=2
        wr_spd(8'd2);
        wr_cmd(32'h51C6BEEF);
        t0 = cyc;
        chk("R1", "busy after launch", 32'(busy), 1);
        chk("R1", "data after launch", mgmt_data, 32'h51C6BEEF);
        do @(negedge clk); while (busy);
        chk("R7", "write frame length", 32'(cyc - t0), 256);
        chk("R7", "flag after write", 32'(evt_flags[23]), 1);
        chk("R11", "data after write", mgmt_data, 32'h51C6BEEF);

        // R8: write-one-to-clear
        wr_evt(32'h0000_0001);
        chk("R8", "flag kept on other bit", 32'(evt_flags[23]), 1);
        wr_evt(32'h0080_0000);
        chk("R8", "flag cleared", 32'(evt_flags[23]), 0);

        // R3/R5/R6: read frame at S=3 with mid-frame writes
        phy_resp = 16'hA5C3;
        wr_spd(8'd3);
        wr_cmd(32'h6F8B0000);
        t0 = cyc;
        repeat (20) @(negedge clk);
        wr_cmd(32'h12345678);
        wr_spd(8'd5);
        chk("R6", "data during busy", mgmt_data, 32'h6F8B0000);
        do @(negedge clk); while (busy);
        chk("R5", "read frame length uses latched speed", 32'(cyc - t0), 384);
        chk("R3", "read result", mgmt_data, 32'h6F8BA5C3);
        chk("R6", "upper half kept", {16'h0, mgmt_data[31:16]}, 32'h6F8B);

        // R9: clear on the completion cycle, S=1
        wr_evt(32'h0080_0000);
        wr_spd(8'd1);
        wr_cmd(32'h5006_1234);
        t0 = cyc;
        do @(negedge clk); while (!(m_busy && m_k == 128 * m_h - 1));
        evt_wr = 1'b1; evt_wdata = 32'h0080_0000;
        @(negedge clk);
        evt_wr = 1'b0;
        chk("R9", "set beats clear", 32'(evt_flags[23]), 1);
        chk("R7", "fast frame length", 32'(cyc - t0), 128);
        wr_evt(32'h0080_0000);
        chk("R8", "final clear", 32'(evt_flags[23]), 0);
        repeat (4) @(negedge clk);
        summary();
    end
endmodule